// File: doc/BRIEF.md
# Reconfigurable Pin Function Crossbar

The crossbar sits between one 8-pin I/O port and a set of internal peripheral signals. Every pin owns a small selector register. The code in that register chooses which peripheral output drives the pin and which peripheral input listens to the pin. The same code decides where the pin's output enable comes from and whether the pin behaves as open-drain. The peripherals, pad cells and input buffers are outside the block. Peripheral signals appear as flat vectors indexed by selector code.

Software reprograms the mapping through a register bus with a 3-bit address, 8-bit write data, a write strobe and a combinational read path. A write lands on the next clock edge. Routing from the stored selector to the pin and peripheral sides is combinational, so a new mapping is visible one cycle after the write.

The selector codes fall into these groups:

| Codes | Group |
|---|---|
| 0 | Ties the pin low |
| 1 to 29 | Peripheral functions |
| 30 | Reserved; behaves as an idle pin |
| 31 | Analog isolation |

Top module: `pin_func_xbar`

## Requirements
- R1: Each selector register keeps only bits [4:0] of a write. Writing 0xFF reads back 31, and read data bits [7:5] are always 0. A write is visible on rdata and on the routing from the cycle after the write strobe, and not before.
- R2: After reset, the selectors of pins 0 to 7 read 13, 15, 14, 16, 12, 11, 27 and 26, in that order.
- R3: Code 0 enables the pin's output driver with a constant low level, and routes the pin to no peripheral input.
- R4: Code 31 turns off the output driver and raises pin_analog. The pin feeds no peripheral input, so every input it could have fed stays at its idle level.
- R5: Code 30 turns off the output driver, keeps pin_analog low and routes no input.
- R6: For codes 1 to 29 outside the open-drain set, pin_out equals per_out[code] and pin_oe equals per_oe[code].
- R7: The open-drain codes are 14, 15, 23, 24, 28 and 29. For these codes pin_out is always 0, and pin_oe is high only while per_oe[code] is 1 and per_out[code] is 0.
- R8: The timer codes 4 to 10 pass the pin level to per_in[code] and drive the pin from per_out[code].
- R9: A peripheral input that no pin selects reads its idle level. The idle level is 1 for codes 11, 14, 15, 20, 23, 24, 26, 28 and 29, and 0 for every other code.
- R10: When several pins select the same input-capable code, per_in[code] follows the lowest-numbered of those pins.
- R11: Codes 17, 18 and 19 are output-only. A pin using one of them drives per_out[code], but per_in[code] stays at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Selector register address (pin number) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Selector of the addressed pin, zero-extended |
| pin_in | input | 8 | Levels seen at the pins |
| pin_out | output | 8 | Output level per pin |
| pin_oe | output | 8 | Output driver enable per pin |
| pin_analog | output | 8 | Analog isolation request per pin |
| per_out | input | 30 | Peripheral output per selector code |
| per_oe | input | 30 | Peripheral direction per selector code |
| per_in | output | 30 | Peripheral input per selector code |

## Verification
The assertions assume the following about the block's inputs:
- rst_n is released away from a clock edge.
- wr_en, addr and wdata are stable around each rising edge.
- addr always names one of the eight pins.

The stimulus meets these assumptions as follows:
- All inputs change only on falling edges.
- Addresses come from the range 0 to 7.
- Peripheral and pin levels are held steady while each group of expectations is sampled, so the combinational routing is checked only after it has settled.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int SEL_W    = 5;
  localparam int NUM_FN   = 30;
  localparam int NUM_PINS = 8;
  localparam int DATA_W   = 8;

  typedef logic [SEL_W-1:0] sel_t;

  localparam sel_t CODE_LOW    = sel_t'(0);
  localparam sel_t CODE_RSVD   = sel_t'((1 << SEL_W) - 2);
  localparam sel_t CODE_ANALOG = sel_t'((1 << SEL_W) - 1);

  // open-drain two-wire clock/data codes
  function automatic logic code_is_od(input int c);
    return (c == 14) || (c == 15) || (c == 23) || (c == 24) ||
           (c == 28) || (c == 29);
  endfunction

  // codes that drive a peripheral input from the pin
  function automatic logic code_takes_in(input int c);
    return ((c >= 1) && (c <= 16)) || ((c >= 20) && (c < NUM_FN));
  endfunction

  // codes that pass a peripheral output and direction to the pin
  function automatic logic code_is_fn(input int c);
    return (c >= 1) && (c < NUM_FN);
  endfunction

  // level presented to an unrouted peripheral input
  function automatic logic idle_level(input int c);
    return code_is_od(c) || (c == 11) || (c == 20) || (c == 26);
  endfunction

  function automatic sel_t reset_sel(input int p);
    case (p)
      0: return sel_t'(13);
      1: return sel_t'(15);
      2: return sel_t'(14);
      3: return sel_t'(16);
      4: return sel_t'(12);
      5: return sel_t'(11);
      6: return sel_t'(27);
      default: return sel_t'(26);
    endcase
  endfunction
endpackage

// File: rtl/pfx_sel_regs.sv
module pfx_sel_regs
  import pfx_pkg::*;
#(
  parameter int PINS  = NUM_PINS,
  parameter int DW    = DATA_W,
  localparam int AW   = $clog2(PINS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  output logic [PINS-1:0][SEL_W-1:0] sel_vec,
  output logic [DW-1:0]           rdata
);
  logic [PINS-1:0] wr_hit;

  for (genvar p = 0; p < PINS; p++) begin : g_reg
    assign wr_hit[p] = wr_en && (addr == AW'(p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sel_vec[p] <= reset_sel(p);
      else if (wr_hit[p])
        sel_vec[p] <= wdata[SEL_W-1:0];
    end
  end

  assign rdata = DW'(sel_vec[addr]);
endmodule

// File: rtl/pfx_pin_drive.sv
module pfx_pin_drive
  import pfx_pkg::*;
#(
  parameter int FN = NUM_FN
) (
  input  sel_t          sel,
  input  logic [FN-1:0] per_out,
  input  logic [FN-1:0] per_oe,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          pin_analog
);
  logic fn_val;
  logic fn_dir;

  always_comb begin
    fn_val = 1'b0;
    fn_dir = 1'b0;
    if (code_is_fn(int'(sel)) && (int'(sel) < FN)) begin
      fn_val = per_out[sel];
      fn_dir = per_oe[sel];
    end
  end

  always_comb begin
    pin_out    = 1'b0;
    pin_oe     = 1'b0;
    pin_analog = 1'b0;
    if (sel == CODE_LOW) begin
      pin_oe = 1'b1;
    end else if (sel == CODE_ANALOG) begin
      pin_analog = 1'b1;
    end else if (code_is_fn(int'(sel))) begin
      if (code_is_od(int'(sel))) begin
        pin_oe = fn_dir & ~fn_val;
      end else begin
        pin_out = fn_val;
        pin_oe  = fn_dir;
      end
    end
  end
endmodule

// File: rtl/pfx_in_route.sv
module pfx_in_route
  import pfx_pkg::*;
#(
  parameter int PINS = NUM_PINS,
  parameter int FN   = NUM_FN
) (
  input  logic [PINS-1:0][SEL_W-1:0] sel_vec,
  input  logic [PINS-1:0]            pin_in,
  output logic [FN-1:0]              per_in
);
  for (genvar f = 0; f < FN; f++) begin : g_fn
    logic [PINS-1:0] hit;
    for (genvar p = 0; p < PINS; p++) begin : g_hit
      assign hit[p] = code_takes_in(f) && (sel_vec[p] == SEL_W'(f));
    end
    always_comb begin
      per_in[f] = idle_level(f);
      for (int p = PINS - 1; p >= 0; p--) begin
        if (hit[p]) per_in[f] = pin_in[p];
      end
    end
  end
endmodule

// File: rtl/pin_func_xbar.sv
module pin_func_xbar
  import pfx_pkg::*;
#(
  parameter int PINS = NUM_PINS,
  parameter int FN   = NUM_FN,
  parameter int DW   = DATA_W,
  localparam int AW  = $clog2(PINS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic [PINS-1:0] pin_analog,
  input  logic [FN-1:0]   per_out,
  input  logic [FN-1:0]   per_oe,
  output logic [FN-1:0]   per_in
);
  logic [PINS-1:0][SEL_W-1:0] sel_vec;

  pfx_sel_regs #(.PINS(PINS), .DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .sel_vec(sel_vec), .rdata(rdata)
  );

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    pfx_pin_drive #(.FN(FN)) drv_i (
      .sel(sel_vec[p]), .per_out(per_out), .per_oe(per_oe),
      .pin_out(pin_out[p]), .pin_oe(pin_oe[p]), .pin_analog(pin_analog[p])
    );
  end

  pfx_in_route #(.PINS(PINS), .FN(FN)) route_i (
    .sel_vec(sel_vec), .pin_in(pin_in), .per_in(per_in)
  );
endmodule

// File: rtl/pfx_chk.sv
module pfx_chk
  import pfx_pkg::*;
#(
  parameter int PINS = NUM_PINS,
  parameter int DW   = DATA_W,
  localparam int AW  = $clog2(PINS)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [AW-1:0]              addr,
  input logic [DW-1:0]              wdata,
  input logic [PINS-1:0][SEL_W-1:0] sel_vec,
  input logic [PINS-1:0]            pin_out,
  input logic [PINS-1:0]            pin_oe,
  input logic [PINS-1:0]            pin_analog
);
  for (genvar p = 0; p < PINS; p++) begin : g_chk
    // R1
    sel_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(p)) |=> (sel_vec[p] == $past(wdata[SEL_W-1:0])));
    // R1
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == AW'(p)) |=> $stable(sel_vec[p]));
    // R3
    low_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_vec[p] == CODE_LOW) |-> (pin_oe[p] && !pin_out[p]));
    // R4
    analog_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_vec[p] == CODE_ANALOG) |-> (!pin_oe[p] && pin_analog[p]));
    // R5
    rsvd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_vec[p] == CODE_RSVD) |-> (!pin_oe[p] && !pin_analog[p]));
    // R7
    od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      code_is_od(int'(sel_vec[p])) |-> !pin_out[p]);
  end
endmodule

bind pin_func_xbar pfx_chk #(.PINS(PINS), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .sel_vec(sel_vec), .pin_out(pin_out), .pin_oe(pin_oe),
  .pin_analog(pin_analog)
);

// File: tb/pin_func_xbar_tb_top.sv
module pin_func_xbar_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int NF = 30;

  // item kinds: 0 rdata, 1 pin_out, 2 pin_oe, 3 pin_analog, 4 per_in
  typedef struct {
    int         req;
    int         kind;
    int         idx;
    logic [7:0] exp;
  } item_t;

  item_t sb_q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, pin_analog;
  logic [NF-1:0] per_out = '0;
  logic [NF-1:0] per_oe = '0;
  logic [NF-1:0] per_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_func_xbar dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_analog(pin_analog), .per_out(per_out), .per_oe(per_oe),
    .per_in(per_in)
  );

  function automatic logic tb_idle(input int c);
    case (c)
      11, 14, 15, 20, 23, 24, 26, 28, 29: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic push(input int req, input int kind, input int idx, input logic [7:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.idx = idx; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic rd_exp(input int req, input int a, input logic [7:0] exp);
    @(negedge clk);
    addr = 3'(a);
    push(req, 0, a, exp);
  endtask

  // write, checking old value before the edge and new value after it
  task automatic wr_sel(input int req, input int a, input logic [7:0] d,
                        input logic [7:0] old_v, input logic [7:0] new_v);
    @(negedge clk);
    wr_en = 1; addr = 3'(a); wdata = d;
    push(req, 0, a, old_v);
    @(negedge clk);
    wr_en = 0;
    push(req, 0, a, new_v);
  endtask

  // monitor: pops expectations after the driver's stimulus has settled
  initial begin
    forever begin
      wait (sb_q.size() != 0);
      #1;
      while (sb_q.size() != 0) begin
        item_t it;
        logic [7:0] got;
        it = sb_q.pop_front();
        case (it.kind)
          0: got = rdata;
          1: got = {7'b0, pin_out[it.idx]};
          2: got = {7'b0, pin_oe[it.idx]};
          3: got = {7'b0, pin_analog[it.idx]};
          default: got = {7'b0, per_in[it.idx]};
        endcase
        total++;
        if (got !== it.exp) begin
          bad++;
          $display("FAIL R%0d kind=%0d idx=%0d actual=%0h expected=%0h",
                   it.req, it.kind, it.idx, got, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int defs[8];
    defs = '{13, 15, 14, 16, 12, 11, 27, 26};
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R2 reset selectors
    for (int a = 0; a < NP; a++) rd_exp(2, a, 8'(defs[a]));

    // R10-style routing sanity with defaults: per_in[11] follows pin 5
    @(negedge clk);
    pin_in = '0;
    push(9, 4, 11, 8'd0);          // R9 routed, not idle
    push(9, 4, 13, 8'd0);

    // R6 serial code 12 on pin 4: direction from peripheral
    @(negedge clk);
    per_oe[12] = 1; per_out[12] = 1;
    push(6, 1, 4, 8'd1); push(6, 2, 4, 8'd1);
    @(negedge clk);
    per_oe[12] = 0;
    push(6, 2, 4, 8'd0);

    // R1 truncation and R4 analog on pin 2
    wr_sel(1, 2, 8'hFF, 8'd14, 8'd31);
    @(negedge clk);
    pin_in = 8'hFF;
    push(4, 2, 2, 8'd0); push(4, 3, 2, 8'd1);
    push(4, 4, 14, 8'd1);          // R4 idle, pin not routed
    push(9, 4, 14, 8'd1);
    push(4, 4, 31 - 2, 8'd1);      // code 29 unselected: idle high

    // R3 code 0 on pin 0
    wr_sel(3, 0, 8'h00, 8'd13, 8'd0);
    @(negedge clk);
    per_out = '1; per_oe = '1;
    push(3, 1, 0, 8'd0); push(3, 2, 0, 8'd1); push(3, 3, 0, 8'd0);
    push(3, 4, 13, 8'd0);          // R9 idle 0, pin_in high ignored

    // R5 reserved on pin 1
    wr_sel(5, 1, 8'd30, 8'd15, 8'd30);
    @(negedge clk);
    push(5, 2, 1, 8'd0); push(5, 3, 1, 8'd0); push(5, 1, 1, 8'd0);
    pin_in = '0;
    push(5, 4, 15, 8'd1);          // idle high

    // R8 timer code 5 on pin 3
    wr_sel(8, 3, 8'd5, 8'd16, 8'd5);
    @(negedge clk);
    pin_in = 8'b0000_1000; per_out = '0; per_oe = '0;
    per_out[5] = 1; per_oe[5] = 1;
    push(8, 4, 5, 8'd1); push(8, 1, 3, 8'd1); push(8, 2, 3, 8'd1);
    @(negedge clk);
    per_oe[5] = 0; pin_in = '0;
    push(6, 2, 3, 8'd0); push(8, 4, 5, 8'd0);

    // R7 open drain code 23 on pin 4
    wr_sel(7, 4, 8'd23, 8'd12, 8'd23);
    @(negedge clk);
    per_oe[23] = 1; per_out[23] = 0;
    push(7, 1, 4, 8'd0); push(7, 2, 4, 8'd1);
    @(negedge clk);
    per_out[23] = 1;
    push(7, 1, 4, 8'd0); push(7, 2, 4, 8'd0);

    // R10 priority: pins 5 and 6 both select code 7
    wr_sel(10, 5, 8'd7, 8'd11, 8'd7);
    wr_sel(10, 6, 8'd7, 8'd27, 8'd7);
    @(negedge clk);
    pin_in = 8'b0100_0000;
    push(10, 4, 7, 8'd0);
    @(negedge clk);
    pin_in = 8'b0010_0000;
    push(10, 4, 7, 8'd1);
    push(9, 4, 11, 8'd1);          // code 11 no longer selected: idle high

    // R11 output-only code 18 on pin 7
    wr_sel(11, 7, 8'd18, 8'd26, 8'd18);
    @(negedge clk);
    pin_in = 8'hFF; per_out[18] = 1; per_oe[18] = 1;
    push(11, 1, 7, 8'd1); push(11, 2, 7, 8'd1);
    push(11, 4, 18, 8'd0);

    // R1 more truncation patterns
    wr_sel(1, 7, 8'h3F, 8'd18, 8'd31);
    wr_sel(1, 7, 8'h47, 8'd31, 8'd7);
    rd_exp(1, 6, 8'd7);

    @(negedge clk);
    wait (sb_q.size() == 0);
    #2;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule